// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits next to a small 32-bit core and takes over the bookkeeping of exception entry. Two request classes arrive as single-cycle pulses. A non-maskable interrupt comes from a watchdog threshold, from a store that hit a bus-error region, or from a DMA store that did the same. A general exception comes from the core with a five-bit cause code, the PC of the faulting instruction and, where relevant, a faulting address. On the clock edge that accepts a request the block updates its control registers: status flags, cause code, the two saved-PC registers, the bad-address register, the register-bank selection pair and the NMI source flags. In the following cycle it presents a fetch redirect vector to the fetch unit.

An exception-return pulse leaves the handler. The block clears the matching status flag, redirects fetch to the saved PC and copies the previous-bank field back into the current-bank field. Entry copies the current-bank field into the previous-bank field and never moves the active bank itself. The core can still select a bank on its own through a bank-write strobe.

The redirect sequencer is a four-state machine. `ST_RUN` is the state with no redirect pending. `ST_NMI_VEC`, `ST_GEN_VEC` and `ST_RET_VEC` each last one cycle and drive the redirect. Every state moves on every clock according to the event accepted on that edge: NMI goes to `ST_NMI_VEC`, a general exception goes to `ST_GEN_VEC`, an accepted return goes to `ST_RET_VEC`, and no event goes to `ST_RUN`. Back-to-back events therefore chain directly between the vector states.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A high level on `wdt_nmi_i` sets NMI flag bit 0. A high level on `st_berr_i` or `dma_st_berr_i` sets NMI flag bit 1. Each of these inputs raises an NMI on that edge.
- R2: An NMI sets status ERL and status NMI to 1. In the next cycle `redirect_valid_o` is 1 and `redirect_pc_o` is 0xBFC0_0000.
- R3: An NMI saves the PC into `errorepc_o`. A general exception saves it into `epc_o` instead, and `errorepc_o` is left unchanged.
- R4: For an NMI, and for a general exception with code 7 (data bus error), the saved PC is `cur_pc_i`, the PC of the instruction executing now. For every other code it is `gen_pc_i`.
- R5: On any entry with `shadow_en_i` = 1, `pss_o` takes the old `css_o`. Entry itself never changes `css_o`.
- R6: An accepted return loads `css_o` from `pss_o`. This takes priority over a bank write on the same edge.
- R7: A general exception writes `gen_code_i` into `cause_code_o` and sets status EXL. The redirect is 0xBFC0_0380 when `bev_i` = 1 and the parameter `RUN_GEN_VEC` (default 0x8000_0180) when `bev_i` = 0.
- R8: Codes 4 (load address error), 5 (store address error), 6 (fetch bus error) and 7 (data bus error) write `gen_addr_i` into `badvaddr_o`. Other codes leave it unchanged.
- R9: A request with `gen_dma_i` = 1 and code 4 or 5 raises no exception and changes no register. It pulses `dma_cfg_err_o` for one cycle, one cycle after the request.
- R10: When an NMI and a general exception arrive on the same edge, the NMI is taken and the general exception is dropped, so cause, EPC and EXL do not change. Either request also blocks a return on that edge.
- R11: Writing 1 to bit i of `flag_clr_i` clears NMI flag bit i. A source event on the same edge wins, and the bit stays 1.
- R12: A general exception taken while EXL or ERL is already 1 leaves `epc_o` unchanged. The redirect and cause still follow R7.
- R13: Return with ERL = 1 clears ERL and NMI and redirects to `errorepc_o`. Otherwise, with EXL = 1, it clears EXL and redirects to `epc_o`. With both 0 the return is ignored: no redirect and no register change.
- R14: `redirect_valid_o` is 1 exactly in the cycle after each accepted NMI, general exception or return, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdt_nmi_i | input | 1 | Watchdog reached its NMI count |
| st_berr_i | input | 1 | Core store hit a bus-error region |
| dma_st_berr_i | input | 1 | DMA store hit a bus-error region |
| gen_req_i | input | 1 | General exception request |
| gen_code_i | input | 5 | Cause code of the request |
| gen_dma_i | input | 1 | Request originates from a DMA transfer |
| gen_pc_i | input | 32 | PC of the faulting instruction |
| gen_addr_i | input | 32 | Faulting address |
| cur_pc_i | input | 32 | PC of the instruction executing now |
| bev_i | input | 1 | Boot-vector select |
| shadow_en_i | input | 1 | Shadow register sets enabled |
| bank_wr_i | input | 1 | Core writes the current bank field |
| bank_wr_val_i | input | 3 | Value for the bank write |
| eret_i | input | 1 | Exception return |
| flag_clr_i | input | 2 | Write-one-to-clear for NMI flags |
| redirect_valid_o | output | 1 | Fetch redirect this cycle |
| redirect_pc_o | output | 32 | Fetch redirect target |
| status_erl_o | output | 1 | Status ERL |
| status_nmi_o | output | 1 | Status NMI |
| status_exl_o | output | 1 | Status EXL |
| cause_code_o | output | 5 | Latched cause code |
| epc_o | output | 32 | Saved PC of a general exception |
| errorepc_o | output | 32 | Saved PC of an NMI |
| badvaddr_o | output | 32 | Latched faulting address |
| css_o | output | 3 | Current bank field |
| pss_o | output | 3 | Previous bank field |
| nmi_flag_o | output | 2 | NMI source flags (bit 0 watchdog, bit 1 store bus error) |
| dma_cfg_err_o | output | 1 | DMA address error pulse |

## Verification
Every piece of state in this block drives an output register directly. A wrong status flag, saved PC or bank field therefore appears at the ports on the first clock after the edge that corrupted it. A broken sequencer state shows up one cycle after the event, as a missing, stuck or mistargeted redirect. A wrong arbitration decision shows up in the same cycle as a change to a register that should have held, such as cause, EPC or the bank fields. A per-cycle reference model catches each of these within one cycle of its cause, under both directed sequences and long random ones.

// File: rtl/exc_pkg.sv
package exc_pkg;

    parameter int EXC_CODE_W = 5;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_NMI  = 2'd1,
        EV_GEN  = 2'd2,
        EV_RET  = 2'd3
    } exc_event_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_NMI_VEC = 2'd1,
        ST_GEN_VEC = 2'd2,
        ST_RET_VEC = 2'd3
    } redir_state_e;

    typedef struct packed {
        logic st;
        logic wdt;
    } nmi_src_t;

    localparam logic [EXC_CODE_W-1:0] XC_LD_ADR  = 5'd4;
    localparam logic [EXC_CODE_W-1:0] XC_ST_ADR  = 5'd5;
    localparam logic [EXC_CODE_W-1:0] XC_FET_BUS = 5'd6;
    localparam logic [EXC_CODE_W-1:0] XC_DAT_BUS = 5'd7;

    function automatic logic code_is_adr(input logic [EXC_CODE_W-1:0] c);
        return (c == XC_LD_ADR) || (c == XC_ST_ADR);
    endfunction

    function automatic logic code_keeps_addr(input logic [EXC_CODE_W-1:0] c);
        return code_is_adr(c) || (c == XC_FET_BUS) || (c == XC_DAT_BUS);
    endfunction

endpackage

// File: rtl/exc_req_arbiter.sv
module exc_req_arbiter
    import exc_pkg::*;
(
    input  logic                  wdt_i,
    input  logic                  st_berr_i,
    input  logic                  dma_st_berr_i,
    input  logic                  gen_req_i,
    input  logic [EXC_CODE_W-1:0] gen_code_i,
    input  logic                  gen_dma_i,
    input  logic                  eret_i,
    input  logic                  erl_i,
    input  logic                  exl_i,
    output exc_event_e            event_o,
    output logic                  dma_adr_o,
    output nmi_src_t              nmi_src_o
);

    logic nmi_any;
    logic gen_ok;
    logic ret_ok;

    always_comb begin
        nmi_src_o.wdt = wdt_i;
        nmi_src_o.st  = st_berr_i | dma_st_berr_i;
        nmi_any       = nmi_src_o.wdt | nmi_src_o.st;
        // DMA address errors never become exceptions
        dma_adr_o     = gen_req_i & gen_dma_i & code_is_adr(gen_code_i);
        gen_ok        = gen_req_i & ~dma_adr_o;
        ret_ok        = eret_i & (erl_i | exl_i);
    end

    always_comb begin
        if (nmi_any)
            event_o = EV_NMI;
        else if (gen_ok)
            event_o = EV_GEN;
        else if (ret_ok)
            event_o = EV_RET;
        else
            event_o = EV_NONE;
    end

endmodule

// File: rtl/exc_redirect_fsm.sv
module exc_redirect_fsm
    import exc_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] NMI_VEC      = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] BOOT_GEN_VEC = 32'hBFC0_0380,
    parameter logic [XLEN-1:0] RUN_GEN_VEC  = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  exc_event_e      event_i,
    input  logic            bev_i,
    input  logic            erl_i,
    input  logic [XLEN-1:0] epc_i,
    input  logic [XLEN-1:0] errorepc_i,
    output logic            redirect_valid_o,
    output logic [XLEN-1:0] redirect_pc_o
);

    redir_state_e    state_q, state_d;
    logic [XLEN-1:0] tgt_q, tgt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    always_comb begin
        state_d = ST_RUN;
        tgt_d   = tgt_q;
        unique case (event_i)
            EV_NMI: begin
                state_d = ST_NMI_VEC;
                tgt_d   = NMI_VEC;
            end
            EV_GEN: begin
                state_d = ST_GEN_VEC;
                tgt_d   = bev_i ? BOOT_GEN_VEC : RUN_GEN_VEC;
            end
            EV_RET: begin
                state_d = ST_RET_VEC;
                tgt_d   = erl_i ? errorepc_i : epc_i;
            end
            EV_NONE: begin
                state_d = ST_RUN;
            end
        endcase
    end

    always_comb begin
        redirect_pc_o = tgt_q;
        unique case (state_q)
            ST_RUN:     redirect_valid_o = 1'b0;
            ST_NMI_VEC: redirect_valid_o = 1'b1;
            ST_GEN_VEC: redirect_valid_o = 1'b1;
            ST_RET_VEC: redirect_valid_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/exc_cp_regs.sv
module exc_cp_regs
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int BANK_W = 3,
    parameter int NFLAG  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  exc_event_e            event_i,
    input  nmi_src_t              nmi_src_i,
    input  logic                  dma_adr_i,
    input  logic [EXC_CODE_W-1:0] gen_code_i,
    input  logic [XLEN-1:0]       gen_pc_i,
    input  logic [XLEN-1:0]       gen_addr_i,
    input  logic [XLEN-1:0]       cur_pc_i,
    input  logic                  shadow_en_i,
    input  logic                  bank_wr_i,
    input  logic [BANK_W-1:0]     bank_wr_val_i,
    input  logic [NFLAG-1:0]      flag_clr_i,
    output logic                  erl_o,
    output logic                  nmi_o,
    output logic                  exl_o,
    output logic [EXC_CODE_W-1:0] cause_o,
    output logic [XLEN-1:0]       epc_o,
    output logic [XLEN-1:0]       errorepc_o,
    output logic [XLEN-1:0]       badvaddr_o,
    output logic [BANK_W-1:0]     css_o,
    output logic [BANK_W-1:0]     pss_o,
    output logic [NFLAG-1:0]      flag_o,
    output logic                  dma_cfg_err_o
);

    logic [NFLAG-1:0] flag_set;
    logic             in_handler;

    assign flag_set   = NFLAG'({nmi_src_i.st, nmi_src_i.wdt});
    assign in_handler = erl_o | exl_o;

    // status bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erl_o <= 1'b0;
            nmi_o <= 1'b0;
            exl_o <= 1'b0;
        end else begin
            unique case (event_i)
                EV_NMI: begin
                    erl_o <= 1'b1;
                    nmi_o <= 1'b1;
                end
                EV_GEN: exl_o <= 1'b1;
                EV_RET: begin
                    if (erl_o) begin
                        erl_o <= 1'b0;
                        nmi_o <= 1'b0;
                    end else begin
                        exl_o <= 1'b0;
                    end
                end
                EV_NONE: ;
            endcase
        end
    end

    // cause, saved PCs, bad address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_o    <= '0;
            epc_o      <= '0;
            errorepc_o <= '0;
            badvaddr_o <= '0;
        end else begin
            if (event_i == EV_NMI)
                errorepc_o <= cur_pc_i;
            if (event_i == EV_GEN) begin
                cause_o <= gen_code_i;
                if (!in_handler)
                    epc_o <= (gen_code_i == XC_DAT_BUS) ? cur_pc_i : gen_pc_i;
                if (code_keeps_addr(gen_code_i))
                    badvaddr_o <= gen_addr_i;
            end
        end
    end

    // bank selection pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            css_o <= '0;
            pss_o <= '0;
        end else begin
            if (event_i == EV_RET)
                css_o <= pss_o;
            else if (bank_wr_i)
                css_o <= bank_wr_val_i;
            if (shadow_en_i && (event_i == EV_NMI || event_i == EV_GEN))
                pss_o <= css_o;
        end
    end

    // NMI source flags, set wins over clear
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_o[i] <= 1'b0;
            else
                flag_o[i] <= flag_set[i] | (flag_o[i] & ~flag_clr_i[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_cfg_err_o <= 1'b0;
        else
            dma_cfg_err_o <= dma_adr_i;
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              BANK_W       = 3,
    parameter logic [XLEN-1:0] NMI_VEC      = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] BOOT_GEN_VEC = 32'hBFC0_0380,
    parameter logic [XLEN-1:0] RUN_GEN_VEC  = 32'h8000_0180
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wdt_nmi_i,
    input  logic                  st_berr_i,
    input  logic                  dma_st_berr_i,
    input  logic                  gen_req_i,
    input  logic [EXC_CODE_W-1:0] gen_code_i,
    input  logic                  gen_dma_i,
    input  logic [XLEN-1:0]       gen_pc_i,
    input  logic [XLEN-1:0]       gen_addr_i,
    input  logic [XLEN-1:0]       cur_pc_i,
    input  logic                  bev_i,
    input  logic                  shadow_en_i,
    input  logic                  bank_wr_i,
    input  logic [BANK_W-1:0]     bank_wr_val_i,
    input  logic                  eret_i,
    input  logic [1:0]            flag_clr_i,
    output logic                  redirect_valid_o,
    output logic [XLEN-1:0]       redirect_pc_o,
    output logic                  status_erl_o,
    output logic                  status_nmi_o,
    output logic                  status_exl_o,
    output logic [EXC_CODE_W-1:0] cause_code_o,
    output logic [XLEN-1:0]       epc_o,
    output logic [XLEN-1:0]       errorepc_o,
    output logic [XLEN-1:0]       badvaddr_o,
    output logic [BANK_W-1:0]     css_o,
    output logic [BANK_W-1:0]     pss_o,
    output logic [1:0]            nmi_flag_o,
    output logic                  dma_cfg_err_o
);

    localparam int NFLAG = $bits(nmi_src_t);

    exc_event_e ev;
    logic       dma_adr;
    nmi_src_t   nmi_src;

    exc_req_arbiter u_arb (
        .wdt_i         (wdt_nmi_i),
        .st_berr_i     (st_berr_i),
        .dma_st_berr_i (dma_st_berr_i),
        .gen_req_i     (gen_req_i),
        .gen_code_i    (gen_code_i),
        .gen_dma_i     (gen_dma_i),
        .eret_i        (eret_i),
        .erl_i         (status_erl_o),
        .exl_i         (status_exl_o),
        .event_o       (ev),
        .dma_adr_o     (dma_adr),
        .nmi_src_o     (nmi_src)
    );

    exc_redirect_fsm #(
        .XLEN         (XLEN),
        .NMI_VEC      (NMI_VEC),
        .BOOT_GEN_VEC (BOOT_GEN_VEC),
        .RUN_GEN_VEC  (RUN_GEN_VEC)
    ) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .event_i          (ev),
        .bev_i            (bev_i),
        .erl_i            (status_erl_o),
        .epc_i            (epc_o),
        .errorepc_i       (errorepc_o),
        .redirect_valid_o (redirect_valid_o),
        .redirect_pc_o    (redirect_pc_o)
    );

    exc_cp_regs #(
        .XLEN   (XLEN),
        .BANK_W (BANK_W),
        .NFLAG  (NFLAG)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .event_i       (ev),
        .nmi_src_i     (nmi_src),
        .dma_adr_i     (dma_adr),
        .gen_code_i    (gen_code_i),
        .gen_pc_i      (gen_pc_i),
        .gen_addr_i    (gen_addr_i),
        .cur_pc_i      (cur_pc_i),
        .shadow_en_i   (shadow_en_i),
        .bank_wr_i     (bank_wr_i),
        .bank_wr_val_i (bank_wr_val_i),
        .flag_clr_i    (flag_clr_i),
        .erl_o         (status_erl_o),
        .nmi_o         (status_nmi_o),
        .exl_o         (status_exl_o),
        .cause_o       (cause_code_o),
        .epc_o         (epc_o),
        .errorepc_o    (errorepc_o),
        .badvaddr_o    (badvaddr_o),
        .css_o         (css_o),
        .pss_o         (pss_o),
        .flag_o        (nmi_flag_o),
        .dma_cfg_err_o (dma_cfg_err_o)
    );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int              XLEN    = 32,
    parameter int              BANK_W  = 3,
    parameter logic [XLEN-1:0] NMI_VEC = 32'hBFC0_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wdt_nmi_i,
    input logic              st_berr_i,
    input logic              dma_st_berr_i,
    input logic              gen_req_i,
    input logic [4:0]        gen_code_i,
    input logic              gen_dma_i,
    input logic              shadow_en_i,
    input logic              bank_wr_i,
    input logic              eret_i,
    input logic [1:0]        flag_clr_i,
    input logic              redirect_valid_o,
    input logic [XLEN-1:0]   redirect_pc_o,
    input logic              status_erl_o,
    input logic              status_nmi_o,
    input logic              status_exl_o,
    input logic [4:0]        cause_code_o,
    input logic [XLEN-1:0]   epc_o,
    input logic [BANK_W-1:0] css_o,
    input logic [BANK_W-1:0] pss_o,
    input logic [1:0]        nmi_flag_o,
    input logic              dma_cfg_err_o
);

    logic nmi_any;
    logic dma_adr_req;

    assign nmi_any     = wdt_nmi_i | st_berr_i | dma_st_berr_i;
    assign dma_adr_req = gen_req_i & gen_dma_i & ((gen_code_i == 5'd4) | (gen_code_i == 5'd5));

    p_nmi_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_any |=> (redirect_valid_o && redirect_pc_o == NMI_VEC && status_erl_o && status_nmi_o));

    p_pss_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_any && shadow_en_i) |=> (pss_o == $past(css_o)));

    p_css_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_any && !bank_wr_i) |=> $stable(css_o));

    p_dma_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_adr_req && !nmi_any && !eret_i) |=> (!redirect_valid_o && dma_cfg_err_o));

    p_nmi_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_any && gen_req_i) |=> $stable(cause_code_o));

    p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i[0] && !wdt_nmi_i) |=> !nmi_flag_o[0]);

    p_epc_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (status_exl_o || status_erl_o) |=> $stable(epc_o));

    p_eret_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_i && !status_erl_o && !status_exl_o && !nmi_any && !gen_req_i) |=> !redirect_valid_o);

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN    (XLEN),
    .BANK_W  (BANK_W),
    .NMI_VEC (NMI_VEC)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .wdt_nmi_i        (wdt_nmi_i),
    .st_berr_i        (st_berr_i),
    .dma_st_berr_i    (dma_st_berr_i),
    .gen_req_i        (gen_req_i),
    .gen_code_i       (gen_code_i),
    .gen_dma_i        (gen_dma_i),
    .shadow_en_i      (shadow_en_i),
    .bank_wr_i        (bank_wr_i),
    .eret_i           (eret_i),
    .flag_clr_i       (flag_clr_i),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .status_erl_o     (status_erl_o),
    .status_nmi_o     (status_nmi_o),
    .status_exl_o     (status_exl_o),
    .cause_code_o     (cause_code_o),
    .epc_o            (epc_o),
    .css_o            (css_o),
    .pss_o            (pss_o),
    .nmi_flag_o       (nmi_flag_o),
    .dma_cfg_err_o    (dma_cfg_err_o)
);

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;

    localparam logic [31:0] V_NMI  = 32'hBFC0_0000;
    localparam logic [31:0] V_BOOT = 32'hBFC0_0380;
    localparam logic [31:0] V_RUN  = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wdt_nmi_i = 0, st_berr_i = 0, dma_st_berr_i = 0;
    logic        gen_req_i = 0, gen_dma_i = 0, bev_i = 1, shadow_en_i = 1;
    logic        bank_wr_i = 0, eret_i = 0;
    logic [4:0]  gen_code_i = 0;
    logic [31:0] gen_pc_i = 0, gen_addr_i = 0, cur_pc_i = 0;
    logic [2:0]  bank_wr_val_i = 0;
    logic [1:0]  flag_clr_i = 0;

    logic        redirect_valid_o;
    logic [31:0] redirect_pc_o;
    logic        status_erl_o, status_nmi_o, status_exl_o;
    logic [4:0]  cause_code_o;
    logic [31:0] epc_o, errorepc_o, badvaddr_o;
    logic [2:0]  css_o, pss_o;
    logic [1:0]  nmi_flag_o;
    logic        dma_cfg_err_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    exc_entry_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .wdt_nmi_i(wdt_nmi_i), .st_berr_i(st_berr_i), .dma_st_berr_i(dma_st_berr_i),
        .gen_req_i(gen_req_i), .gen_code_i(gen_code_i), .gen_dma_i(gen_dma_i),
        .gen_pc_i(gen_pc_i), .gen_addr_i(gen_addr_i), .cur_pc_i(cur_pc_i),
        .bev_i(bev_i), .shadow_en_i(shadow_en_i), .bank_wr_i(bank_wr_i),
        .bank_wr_val_i(bank_wr_val_i), .eret_i(eret_i), .flag_clr_i(flag_clr_i),
        .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
        .status_erl_o(status_erl_o), .status_nmi_o(status_nmi_o), .status_exl_o(status_exl_o),
        .cause_code_o(cause_code_o), .epc_o(epc_o), .errorepc_o(errorepc_o),
        .badvaddr_o(badvaddr_o), .css_o(css_o), .pss_o(pss_o),
        .nmi_flag_o(nmi_flag_o), .dma_cfg_err_o(dma_cfg_err_o)
    );

    // behavioural reference model
    logic        m_rv, m_erl, m_nmi, m_exl, m_dcfg;
    logic [31:0] m_rpc, m_epc, m_eepc, m_bad;
    logic [4:0]  m_cause;
    logic [2:0]  m_css, m_pss;
    logic [1:0]  m_flag;

    always @(posedge clk) begin : model
        logic nmi_t, adr_t, dmaadr_t, gen_t, ret_t, o_erl, o_exl;
        logic [2:0] o_css, o_pss;
        if (!rst_n) begin
            m_rv = 0; m_erl = 0; m_nmi = 0; m_exl = 0; m_dcfg = 0;
            m_rpc = 0; m_epc = 0; m_eepc = 0; m_bad = 0; m_cause = 0;
            m_css = 0; m_pss = 0; m_flag = 0;
        end else begin
            o_erl = m_erl; o_exl = m_exl; o_css = m_css; o_pss = m_pss;
            nmi_t    = wdt_nmi_i | st_berr_i | dma_st_berr_i;
            adr_t    = (gen_code_i == 5'd4) || (gen_code_i == 5'd5);
            dmaadr_t = gen_req_i && gen_dma_i && adr_t;
            gen_t    = gen_req_i && !dmaadr_t && !nmi_t;
            ret_t    = eret_i && !nmi_t && !gen_t && !dmaadr_t ? (o_erl || o_exl) : 1'b0;
            if (eret_i && !nmi_t && !gen_t && dmaadr_t) ret_t = o_erl || o_exl;
            m_rv = nmi_t || gen_t || ret_t;
            if (nmi_t) m_rpc = V_NMI;
            else if (gen_t) m_rpc = bev_i ? V_BOOT : V_RUN;
            else if (ret_t) m_rpc = o_erl ? m_eepc : m_epc;
            m_flag[0] = wdt_nmi_i | (m_flag[0] & ~flag_clr_i[0]);
            m_flag[1] = st_berr_i | dma_st_berr_i | (m_flag[1] & ~flag_clr_i[1]);
            m_dcfg = dmaadr_t;
            if (nmi_t) begin
                m_erl = 1; m_nmi = 1; m_eepc = cur_pc_i;
                if (shadow_en_i) m_pss = o_css;
            end else if (gen_t) begin
                m_exl = 1; m_cause = gen_code_i;
                if (!o_erl && !o_exl) m_epc = (gen_code_i == 5'd7) ? cur_pc_i : gen_pc_i;
                if (gen_code_i >= 5'd4 && gen_code_i <= 5'd7) m_bad = gen_addr_i;
                if (shadow_en_i) m_pss = o_css;
            end else if (ret_t) begin
                if (o_erl) begin m_erl = 0; m_nmi = 0; end
                else m_exl = 0;
            end
            if (ret_t) m_css = o_pss;
            else if (bank_wr_i) m_css = bank_wr_val_i;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R14 redirect_valid", 32'(redirect_valid_o), 32'(m_rv));
        if (m_rv) chk("R2/R7/R13 redirect_pc", redirect_pc_o, m_rpc);
        chk("R2 status_erl", 32'(status_erl_o), 32'(m_erl));
        chk("R2 status_nmi", 32'(status_nmi_o), 32'(m_nmi));
        chk("R7 status_exl", 32'(status_exl_o), 32'(m_exl));
        chk("R7 cause", 32'(cause_code_o), 32'(m_cause));
        chk("R3 epc", epc_o, m_epc);
        chk("R3 errorepc", errorepc_o, m_eepc);
        chk("R8 badvaddr", badvaddr_o, m_bad);
        chk("R6 css", 32'(css_o), 32'(m_css));
        chk("R5 pss", 32'(pss_o), 32'(m_pss));
        chk("R1 nmi_flag", 32'(nmi_flag_o), 32'(m_flag));
        chk("R9 dma_cfg_err", 32'(dma_cfg_err_o), 32'(m_dcfg));
    endtask

    task automatic idle();
        wdt_nmi_i = 0; st_berr_i = 0; dma_st_berr_i = 0;
        gen_req_i = 0; gen_dma_i = 0; bank_wr_i = 0; eret_i = 0; flag_clr_i = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic gen(input logic [4:0] code, input logic [31:0] pc, input logic [31:0] adr);
        gen_req_i = 1; gen_code_i = code; gen_pc_i = pc; gen_addr_i = adr;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL R14 watchdog actual=%0d expected<20000 cycles", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_all();
        chk("R1 reset flags", 32'(nmi_flag_o), 32'd0);
        chk("R14 reset redirect", 32'(redirect_valid_o), 32'd0);

        // R5: bank write, then system call with shadow enabled and BEV=1
        bank_wr_i = 1; bank_wr_val_i = 3'd5; step(); idle();
        cur_pc_i = 32'h0000_1040; gen(5'd8, 32'h0000_1000, 32'h0); step(); idle();
        chk("R7 boot vector", redirect_pc_o, V_BOOT);
        chk("R3 epc from gen_pc", epc_o, 32'h0000_1000);
        chk("R5 pss copied", 32'(pss_o), 32'd5);
        chk("R5 css unchanged", 32'(css_o), 32'd5);
        step();
        chk("R14 single cycle redirect", 32'(redirect_valid_o), 32'd0);

        // R6: core moves bank, return restores from previous field
        bank_wr_i = 1; bank_wr_val_i = 3'd2; step(); idle();
        eret_i = 1; bank_wr_i = 1; bank_wr_val_i = 3'd6; step(); idle();
        chk("R6 css restored", 32'(css_o), 32'd5);
        chk("R13 return to epc", redirect_pc_o, 32'h0000_1000);

        // R13: return outside handler is ignored
        eret_i = 1; step(); idle();
        chk("R13 ignored return", 32'(redirect_valid_o), 32'd0);

        // R4/R8: asynchronous data bus error records executing PC
        cur_pc_i = 32'h0000_2040; gen(5'd7, 32'h0000_2000, 32'hDEAD_0000); step(); idle();
        chk("R4 epc is current pc", epc_o, 32'h0000_2040);
        chk("R8 badvaddr", badvaddr_o, 32'hDEAD_0000);
        // R12: nested general exception keeps epc, BEV=0 uses run vector
        bev_i = 0; gen(5'd10, 32'h0000_3000, 32'h1111_1111); step(); idle();
        chk("R12 epc held", epc_o, 32'h0000_2040);
        chk("R7 run vector", redirect_pc_o, V_RUN);
        chk("R8 badvaddr unchanged", badvaddr_o, 32'hDEAD_0000);
        eret_i = 1; step(); idle();
        bev_i = 1;

        // R1/R2/R3: watchdog NMI
        cur_pc_i = 32'h0000_4000; wdt_nmi_i = 1; step(); idle();
        chk("R1 wdt flag", 32'(nmi_flag_o), 32'd1);
        chk("R2 nmi vector", redirect_pc_o, V_NMI);
        chk("R3 errorepc", errorepc_o, 32'h0000_4000);
        flag_clr_i = 2'b01; step(); idle();
        chk("R11 flag cleared", 32'(nmi_flag_o), 32'd0);
        eret_i = 1; step(); idle();
        chk("R13 return to errorepc", redirect_pc_o, 32'h0000_4000);
        chk("R13 erl cleared", 32'(status_erl_o), 32'd0);

        // R1/R11: DMA store bus error, set wins over clear
        dma_st_berr_i = 1; flag_clr_i = 2'b10; step(); idle();
        chk("R11 set wins", 32'(nmi_flag_o), 32'd2);
        eret_i = 1; step(); idle();

        // R10: NMI and general exception together
        st_berr_i = 1; gen(5'd9, 32'h0000_5000, 32'h0); step(); idle();
        chk("R10 nmi wins vector", redirect_pc_o, V_NMI);
        chk("R10 exl not set", 32'(status_exl_o), 32'd0);
        chk("R10 cause kept", 32'(cause_code_o), 32'd10);
        eret_i = 1; step(); idle();

        // R9: DMA address error
        gen(5'd4, 32'h0000_6000, 32'hBEEF_0000); gen_dma_i = 1; step(); idle();
        chk("R9 no redirect", 32'(redirect_valid_o), 32'd0);
        chk("R9 cfg error pulse", 32'(dma_cfg_err_o), 32'd1);
        chk("R9 badvaddr untouched", badvaddr_o, 32'hDEAD_0000);
        step();
        chk("R9 pulse ends", 32'(dma_cfg_err_o), 32'd0);
        gen(5'd5, 32'h0000_7000, 32'hBEEF_0004); step(); idle();
        chk("R8 store address error", badvaddr_o, 32'hBEEF_0004);
        eret_i = 1; step(); idle();

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            wdt_nmi_i     = ($urandom % 23) == 0;
            st_berr_i     = ($urandom % 29) == 0;
            dma_st_berr_i = ($urandom % 31) == 0;
            gen_req_i     = ($urandom % 6) == 0;
            gen_code_i    = 5'(4 + ($urandom % 7));
            gen_dma_i     = ($urandom % 4) == 0;
            gen_pc_i      = $urandom;
            gen_addr_i    = $urandom;
            cur_pc_i      = $urandom;
            bev_i         = 1'($urandom);
            shadow_en_i   = ($urandom % 4) != 0;
            bank_wr_i     = ($urandom % 7) == 0;
            bank_wr_val_i = 3'($urandom);
            eret_i        = ($urandom % 4) == 0;
            flag_clr_i    = 2'($urandom);
            step();
        end
        idle();
        step();
        summary();
        $finish;
    end

endmodule